// File: doc/BRIEF.md
# Programmable Serial Baud Rate Generator

This block produces the two timing enables that a serial receiver and transmitter need: a sampling enable and a bit-period (baud) enable. Both are one-cycle pulses in the system clock domain, not derived clocks. The tick source can be one of three options. The first is the system clock itself. The second is the system clock divided by a fixed prescaler of eight. The third is an external serial clock pin, which is synchronised and edge-detected. The chosen source feeds a 16-bit programmable divider.

The divider output is the sampling enable. In asynchronous mode, a second counter divides the sampling pulses by 16 or by 8 to form the baud enable. In synchronous mode, the divider output serves directly as the baud enable. Two divisor codes are special: zero stops all pulses, and one bypasses the divider.

Any change to the source select, divisor, oversampling bit or mode bit restarts every counter. This prevents a shortened or glitched period from reaching the serial engine.

Top module: `brg_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sampleEn` and `baudEn` are 0.
- R2: With `srcSel` = 0 (system clock) and divisor N ≥ 2, `sampleEn` pulses once every N cycles.
- R3: With `srcSel` = 1 (prescaled by 8) and divisor N, `sampleEn` pulses once every 8·N cycles.
- R4: With `srcSel` = 3, each rising edge of `extClk` (after a two-flop synchroniser) is one source tick. With an external period of P system cycles, `sampleEn` pulses every P·N cycles.
- R5: `srcSel` = 2 is reserved and produces no source ticks, so both outputs stay 0.
- R6: A divisor of 0 keeps both outputs at 0.
- R7: A divisor of 1 bypasses the divider, so every source tick gives a `sampleEn` pulse. With the system clock source, that is every cycle.
- R8: In asynchronous mode (`syncMode` = 0), `baudEn` pulses on every 16th `sampleEn` pulse when `overSel` = 0, and on every 8th when `overSel` = 1. Each `baudEn` pulse falls in the same cycle as a `sampleEn` pulse.
- R9: In synchronous mode (`syncMode` = 1), `baudEn` equals `sampleEn` in every cycle.
- R10: A change of any configuration input restarts the counters. After the clock edge that sees the change, no pulse appears. With the system clock source and divisor N, the first `sampleEn` follows N edges after that edge. The first asynchronous `baudEn` follows N·8 edges after it (with `overSel` = 1) or N·16 edges (with `overSel` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSel | input | 2 | Tick source: 0 system clock, 1 prescaled by 8, 2 reserved, 3 external pin |
| divisor | input | 16 | Divider value; 0 stops, 1 bypasses |
| overSel | input | 1 | 1: baud = sampling/8, 0: baud = sampling/16 |
| syncMode | input | 1 | 1: baud enable taken straight from the divider |
| extClk | input | 1 | External serial clock, asynchronous to `clk` |
| sampleEn | output | 1 | One-cycle sampling enable |
| baudEn | output | 1 | One-cycle bit-period enable |

## Verification
The sampling pulse and the baud pulse must land in the same cycle whenever the oversampling counter wraps. The bench runs windows that are exact multiples of the baud period. It counts both pulses and counts any baud pulse seen without a sampling pulse, and that second count must be zero. A second collision is a configuration change that lands while a pulse is already due. The bench changes the divisor and the oversampling bit mid-period. It then checks that nothing emerges after the change edge, and that the first pulses arrive exactly a full new period later.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_PRE = 2'd1,
    SRC_RSV = 2'd2,
    SRC_EXT = 2'd3
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic srcTick;   // one selected-source tick
    logic restart;   // configuration changed this cycle
  } brgStrobe_t;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int PRE_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       srcSel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             overSel,
  input  logic             syncMode,
  input  logic             extClk,
  output brgStrobe_t       strobe
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int CFG_W = 2 + DIV_W + 2;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [CFG_W-1:0]       cfgNow;
  logic [CFG_W-1:0]       cfgQ;
  logic                   restart;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extLast;
  logic                   extRise;
  logic [PRE_W-1:0]       preCnt;
  logic                   preTick;
  logic                   rawTick;

  assign cfgNow  = {srcSel, divisor, overSel, syncMode};
  assign restart = (cfgNow != cfgQ);

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgNow;
  end

  // external pin synchroniser and rising-edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      extLast <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extClk};
      extLast <= syncQ[SYNC_STAGES-1];
    end
  end
  assign extRise = syncQ[SYNC_STAGES-1] & ~extLast;

  // fixed prescaler
  always_ff @(posedge clk) begin
    if (!rstN || restart) preCnt <= '0;
    else if (srcSel_e'(srcSel) == SRC_PRE)
      preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
  end
  assign preTick = (preCnt == PRE_LAST);

  always_comb begin
    case (srcSel_e'(srcSel))
      SRC_SYS: rawTick = 1'b1;
      SRC_PRE: rawTick = preTick;
      SRC_EXT: rawTick = extRise;
      default: rawTick = 1'b0;
    endcase
  end

  assign strobe.restart = restart;
  assign strobe.srcTick = rawTick & ~restart;

  // R5
  rsv_src_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd2) |-> !strobe.srcTick);

  // R3
  pre_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd1 && strobe.srcTick) |=> !strobe.srcTick);

  // R4
  ext_single_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd3 && strobe.srcTick) |=> !strobe.srcTick);
endmodule

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  brgStrobe_t       strobe,
  input  logic [DIV_W-1:0] divisor,
  input  logic             overSel,
  input  logic             syncMode,
  output logic             sampleEn,
  output logic             baudEn
);
  localparam int OVS_W = $clog2(OVS_HI);
  localparam logic [OVS_W-1:0] TOP_HI = OVS_W'(OVS_HI - 1);
  localparam logic [OVS_W-1:0] TOP_LO = OVS_W'(OVS_LO - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic             divStop;
  logic             bypass;
  logic             sampleTick;
  logic [OVS_W-1:0] sampCnt;
  logic [OVS_W-1:0] sampTop;
  logic             baudTick;

  assign divLast = divisor - DIV_W'(1);
  assign divStop = (divisor == '0);
  assign bypass  = (divisor == DIV_W'(1));
  assign sampTop = overSel ? TOP_LO : TOP_HI;

  always_comb begin
    sampleTick = 1'b0;
    if (!divStop && strobe.srcTick)
      sampleTick = bypass || (divCnt == divLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) divCnt <= '0;
    else if (strobe.srcTick && !divStop && !bypass)
      divCnt <= (divCnt == divLast) ? '0 : divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) sampCnt <= '0;
    else if (sampleTick && !syncMode)
      sampCnt <= (sampCnt == sampTop) ? '0 : sampCnt + 1'b1;
  end

  assign baudTick = sampleTick && (syncMode || sampCnt == sampTop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleEn <= 1'b0;
      baudEn   <= 1'b0;
    end else begin
      sampleEn <= sampleTick;
      baudEn   <= baudTick;
    end
  end

  // R6
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |=> (!sampleEn && !baudEn));

  // R8
  baud_on_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudEn |-> sampleEn);

  // R9
  sync_baud_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncMode |=> (baudEn == sampleEn));

  // R10
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (!sampleEn && !baudEn));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.restart |-> (sampCnt <= sampTop));

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && divisor > DIV_W'(1)) |-> (divCnt < divisor));
endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int PRE_DIV     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OVS_HI      = 16,
  parameter int OVS_LO      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       srcSel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             overSel,
  input  logic             syncMode,
  input  logic             extClk,
  output logic             sampleEn,
  output logic             baudEn
);
  brgStrobe_t strobe;

  brg_ctrl #(
    .DIV_W(DIV_W), .PRE_DIV(PRE_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .divisor(divisor),
    .overSel(overSel), .syncMode(syncMode), .extClk(extClk),
    .strobe(strobe)
  );

  brg_datapath #(
    .DIV_W(DIV_W), .OVS_HI(OVS_HI), .OVS_LO(OVS_LO)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divisor(divisor),
    .overSel(overSel), .syncMode(syncMode),
    .sampleEn(sampleEn), .baudEn(baudEn)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!sampleEn && !baudEn));
endmodule

// File: tb/brg_top_tb_top.sv
module brg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  srcSel = 2'd0;
  logic [15:0] divisor = 16'd0;
  logic        overSel = 1'b0;
  logic        syncMode = 1'b0;
  logic        extClk = 1'b0;
  logic        sampleEn;
  logic        baudEn;
  logic        extRun = 1'b0;
  int          errs = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brg_top dut_i (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .divisor(divisor),
    .overSel(overSel), .syncMode(syncMode), .extClk(extClk),
    .sampleEn(sampleEn), .baudEn(baudEn)
  );

  // external clock: 3 cycles high, 3 low (period 6)
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (extRun) begin
        ph++;
        if (ph == 3) begin
          extClk = ~extClk;
          ph = 0;
        end
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic setCfg(input logic [1:0] s, input int d, input logic o, input logic y);
    @(negedge clk);
    srcSel = s; divisor = 16'(d); overSel = o; syncMode = y;
  endtask

  // cycles between two successive pulses; -1 on timeout
  task automatic gap(input bit useBaud, output int g);
    int n = 0;
    g = -1;
    do begin @(negedge clk); n++; end while (!(useBaud ? baudEn : sampleEn) && n < LIM);
    if (n >= LIM) return;
    n = 0;
    do begin @(negedge clk); n++; end while (!(useBaud ? baudEn : sampleEn) && n < LIM);
    if (n < LIM) g = n;
  endtask

  task automatic window(input int cyc, output int s, output int b, output int bad, output int mism);
    s = 0; b = 0; bad = 0; mism = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (sampleEn) s++;
      if (baudEn) b++;
      if (baudEn && !sampleEn) bad++;
      if (baudEn != sampleEn) mism++;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    srcSel = 2'd0; divisor = 16'd1; overSel = 1'b1; syncMode = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sampleEn in reset", int'(sampleEn), 0);
    check("R1 baudEn in reset", int'(baudEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 sampleEn first cycle", int'(sampleEn), 0);
    check("R1 baudEn first cycle", int'(baudEn), 0);
  endtask

  task automatic testSysDiv();
    int g;
    setCfg(2'd0, 5, 1'b0, 1'b0);
    gap(1'b0, g); check("R2 sample gap div5", g, 5);
    gap(1'b1, g); check("R8 baud gap x16 div5", g, 80);
  endtask

  task automatic testOver8();
    int g, s, b, bad, mism;
    setCfg(2'd0, 3, 1'b1, 1'b0);
    gap(1'b1, g); check("R8 baud gap x8 div3", g, 24);
    window(240, s, b, bad, mism);
    check("R8 sample count", s, 80);
    check("R8 baud count", b, 10);
    check("R8 baud without sample", bad, 0);
  endtask

  task automatic testBypass();
    int g;
    setCfg(2'd0, 1, 1'b1, 1'b0);
    gap(1'b0, g); check("R7 bypass sample gap", g, 1);
    gap(1'b1, g); check("R8 max rate baud gap", g, 8);
  endtask

  task automatic testPresc();
    int g;
    setCfg(2'd1, 1, 1'b0, 1'b0);
    gap(1'b0, g); check("R3 prescaled gap div1", g, 8);
    setCfg(2'd1, 4, 1'b0, 1'b0);
    gap(1'b0, g); check("R3 prescaled gap div4", g, 32);
  endtask

  task automatic testExt();
    int g;
    extRun = 1'b1;
    setCfg(2'd3, 1, 1'b0, 1'b0);
    gap(1'b0, g); check("R4 ext gap div1", g, 6);
    setCfg(2'd3, 2, 1'b0, 1'b0);
    gap(1'b0, g); check("R4 ext gap div2", g, 12);
    extRun = 1'b0;
  endtask

  task automatic testReserved();
    int s, b, bad, mism;
    setCfg(2'd2, 3, 1'b1, 1'b0);
    window(500, s, b, bad, mism);
    check("R5 reserved sample count", s, 0);
    check("R5 reserved baud count", b, 0);
  endtask

  task automatic testStop();
    int s, b, bad, mism;
    setCfg(2'd0, 0, 1'b1, 1'b1);
    window(300, s, b, bad, mism);
    check("R6 stop sample count", s, 0);
    check("R6 stop baud count", b, 0);
  endtask

  task automatic testSync();
    int g, s, b, bad, mism;
    setCfg(2'd0, 4, 1'b0, 1'b1);
    gap(1'b1, g); check("R9 sync baud gap", g, 4);
    window(200, s, b, bad, mism);
    check("R9 sync sample count", s, 50);
    check("R9 sync baud count", b, 50);
    check("R9 sync mismatch cycles", mism, 0);
  endtask

  task automatic testRestart();
    int k;
    setCfg(2'd0, 6, 1'b0, 1'b0);
    repeat (9) @(negedge clk);
    divisor = 16'd7;                     // mid-period change
    @(posedge clk);                      // edge that sees it
    @(negedge clk);
    check("R10 quiet after change edge", int'(sampleEn | baudEn), 0);
    k = 0;
    do begin @(negedge clk); k++; end while (!sampleEn && k < LIM);
    check("R10 first sample after restart", k, 7);
    divisor = 16'd2; overSel = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 quiet after second change", int'(sampleEn | baudEn), 0);
    k = 0;
    do begin @(negedge clk); k++; end while (!baudEn && k < LIM);
    check("R10 first baud after restart", k, 16);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    testReset();
    testSysDiv();
    testOver8();
    testBypass();
    testPresc();
    testExt();
    testReserved();
    testStop();
    testSync();
    testRestart();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule